// File: doc/BRIEF.md
# Reset Release Delay Sequencer

This block keeps the processor core in reset for a counted interval after a reset cause goes away. It runs from a slow, free-running time base that is separate from the core clock, delivered as a one-cycle `tick` enable. Four causes are recognised. Power-on and the master-clear pin are level requests: the core is held for as long as either one is active, and the interval begins when both are gone. Watchdog time-out, including a time-out that wakes the part from sleep, and wake-up on pin change are single-cycle pulses: each one starts the interval at once.

The length of the interval is chosen from four parameters. The choice depends on the oscillator class and on whether the reset came from power-on or from a later cause. Resonator-based modes always need the long settling time. Clock-input and RC modes need a medium interval after power-on and a very short one otherwise. A new cause that arrives during an interval restarts the count from zero, using the length that belongs to the new cause and to the oscillator code present at that moment.

The controller has three states. HOLD holds while a level request is active. COUNT runs the interval. RUN has the core released. It takes these transitions: HOLD to COUNT when all level requests are gone; COUNT to COUNT (reload) on a pulse cause; COUNT to RUN on the final tick; COUNT or RUN to HOLD when a level request appears; RUN to COUNT on a pulse cause.

Top module: `rst_dly_seq`

## Requirements
- R1: While `por_req` is 1 or `mclr_n` is 0, `core_hold` is 1 from the next clock edge onward, and no ticks are counted.
- R2: When the interval follows a power-on request, its length in ticks is `LONG_DLY` for a resonator-class code and `FAST_POR_DLY` for a fast-class code.
- R3: When the interval follows a master-clear, watchdog or wake cause, its length is `LONG_DLY` for a resonator-class code and `FAST_LATER_DLY` for a fast-class code.
- R4: `osc_mode` codes 0, 1 and 2 form the resonator class.
- R5: `osc_mode` codes 3 through 7 form the fast class.
- R6: A one-cycle pulse on `wdt_timeout` or `pin_wake` holds the core and starts an interval of the later-reset length, whether the core was running or counting.
- R7: A cause that arrives during an interval restarts the count from zero. The new length follows the new cause type and the `osc_mode` value sampled when the restart happens.
- R8: `core_hold` is registered. It falls at the clock edge that samples the N-th `tick` of an N-tick interval, and not earlier.
- R9: When a pulse cause and a `tick` fall in the same cycle, the restart wins and that tick is not counted, even if it would have been the final tick.
- R10: A pulse cause that arrives while a power-on request is still active does not change the interval type: after release, the power-on length applies.
- R11: After `rst_n` is deasserted, `core_hold` is 1 and the block treats itself as coming out of power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow time-base clock |
| rst_n | input | 1 | Asynchronous reset of the block's own registers, active low |
| tick | input | 1 | One-cycle count enable from the slow time base |
| por_req | input | 1 | Power-on request, level, active high |
| mclr_n | input | 1 | Master-clear pin, level, active low |
| wdt_timeout | input | 1 | Watchdog time-out pulse (awake or asleep) |
| pin_wake | input | 1 | Wake-on-pin-change pulse |
| osc_mode | input | 3 | Oscillator mode code; 0-2 resonator class, 3-7 fast class |
| core_hold | output | 1 | Registered hold-in-reset to the core, active high |

## Verification
Two things can land on the same clock edge: the final tick of an interval and a fresh restart pulse. The bench stops ticking one tick short of the end, then drives a wake pulse together with the tick that would have ended the interval. `core_hold` must stay high, and a complete new interval must then be needed before release. A second case puts a pulse beside a still-active power-on level, and a third changes `osc_mode` at the moment of a restart. In each case the release tick is compared with the length the bench computes from the mode class and the cause.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } rdt_state_e;

    // Codes 0..2 are resonator based; everything else is the fast class.
    function automatic logic is_resonator(input logic [2:0] code);
        return (code <= 3'd2);
    endfunction

endpackage

// File: rtl/rdt_limit_sel.sv
module rdt_limit_sel
    import rdt_pkg::*;
#(
    parameter int CNT_W          = 11,
    parameter int LONG_DLY       = 1800,
    parameter int FAST_POR_DLY   = 113,
    parameter int FAST_LATER_DLY = 1
) (
    input  logic [2:0]       osc_mode,
    input  logic             from_por,
    output logic [CNT_W-1:0] limit
);

    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(LONG_DLY);
    localparam logic [CNT_W-1:0] L_FPOR  = CNT_W'(FAST_POR_DLY);
    localparam logic [CNT_W-1:0] L_FLATE = CNT_W'(FAST_LATER_DLY);

    always_comb begin
        unique case ({is_resonator(osc_mode), from_por})
            2'b10, 2'b11: limit = L_LONG;
            2'b01:        limit = L_FPOR;
            default:      limit = L_FLATE;
        endcase
    end

endmodule

// File: rtl/rdt_tick_cnt.sv
module rdt_tick_cnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             count_en,
    input  logic             tick,
    output logic             last_tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= ONE;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= limit_in;
        end else if (count_en && tick && !last_tick) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign last_tick = count_en && tick && (cnt_q == lim_q - ONE);

    // R7: a running count never reaches its latched limit
    a_r7_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> (cnt_q < lim_q));

    // R7: a reload always starts the count from zero
    a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

endmodule

// File: rtl/rdt_ctrl_fsm.sv
module rdt_ctrl_fsm
    import rdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por_req,
    input  logic mclr_n,
    input  logic restart_pulse,
    input  logic last_tick,
    output logic load,
    output logic from_por,
    output logic count_en,
    output logic core_hold
);

    rdt_state_e state_q, state_d;
    logic       por_cause_q, por_cause_d;
    logic       level_req;

    assign level_req = por_req | ~mclr_n;

    // next state and load control
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        from_por = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (!level_req) begin
                    state_d  = ST_COUNT;
                    load     = 1'b1;
                    from_por = por_cause_q;
                end
            end
            ST_COUNT: begin
                if (level_req) begin
                    state_d = ST_HOLD;
                end else if (restart_pulse) begin
                    load = 1'b1;
                end else if (last_tick) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (level_req) begin
                    state_d = ST_HOLD;
                end else if (restart_pulse) begin
                    state_d = ST_COUNT;
                    load    = 1'b1;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // cause type: power-on outranks every later cause
    always_comb begin
        if (por_req)
            por_cause_d = 1'b1;
        else if (level_req || restart_pulse)
            por_cause_d = 1'b0;
        else
            por_cause_d = por_cause_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_HOLD;
            por_cause_q <= 1'b1;
        end else begin
            state_q     <= state_d;
            por_cause_q <= por_cause_d;
        end
    end

    // registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            core_hold <= 1'b1;
        else
            core_hold <= (state_d != ST_RUN);
    end

    assign count_en = (state_q == ST_COUNT);

    a_r1_hold_on_level: assert property (@(posedge clk) disable iff (!rst_n)
        level_req |=> core_hold);

    a_r6_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> core_hold);

    a_r8_release_on_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> $past(last_tick));

    a_r9_restart_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_pulse && last_tick) |=> (core_hold && state_q == ST_COUNT));

endmodule

// File: rtl/rst_dly_seq.sv
module rst_dly_seq
    import rdt_pkg::*;
#(
    parameter int LONG_DLY       = 1800,
    parameter int FAST_POR_DLY   = 113,
    parameter int FAST_LATER_DLY = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       por_req,
    input  logic       mclr_n,
    input  logic       wdt_timeout,
    input  logic       pin_wake,
    input  logic [2:0] osc_mode,
    output logic       core_hold
);

    localparam int MAX_A   = (LONG_DLY > FAST_POR_DLY) ? LONG_DLY : FAST_POR_DLY;
    localparam int MAX_DLY = (MAX_A > FAST_LATER_DLY) ? MAX_A : FAST_LATER_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    logic             restart_pulse;
    logic             load;
    logic             from_por;
    logic             count_en;
    logic             last_tick;
    logic [CNT_W-1:0] limit;

    assign restart_pulse = wdt_timeout | pin_wake;

    rdt_limit_sel #(
        .CNT_W         (CNT_W),
        .LONG_DLY      (LONG_DLY),
        .FAST_POR_DLY  (FAST_POR_DLY),
        .FAST_LATER_DLY(FAST_LATER_DLY)
    ) u_limit (
        .osc_mode(osc_mode),
        .from_por(from_por),
        .limit   (limit)
    );

    rdt_tick_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .limit_in (limit),
        .count_en (count_en),
        .tick     (tick),
        .last_tick(last_tick)
    );

    rdt_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_req      (por_req),
        .mclr_n       (mclr_n),
        .restart_pulse(restart_pulse),
        .last_tick    (last_tick),
        .load         (load),
        .from_por     (from_por),
        .count_en     (count_en),
        .core_hold    (core_hold)
    );

    // R11: the first edge after reset release still holds the core
    a_r11_hold_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> core_hold);

    // R8: release only ever happens on a tick edge
    a_r8_release_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_hold) |-> $past(tick));

endmodule

// File: tb/rst_dly_seq_bench.sv
module rst_dly_seq_bench;

    localparam int LONG_N  = 48;
    localparam int FPOR_N  = 3;
    localparam int FLATE_N = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       por_req = 1'b0;
    logic       mclr_n = 1'b1;
    logic       wdt_timeout = 1'b0;
    logic       pin_wake = 1'b0;
    logic [2:0] osc_mode = 3'd0;
    logic       core_hold;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rst_dly_seq #(
        .LONG_DLY      (LONG_N),
        .FAST_POR_DLY  (FPOR_N),
        .FAST_LATER_DLY(FLATE_N)
    ) u_rst_dly_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .por_req    (por_req),
        .mclr_n     (mclr_n),
        .wdt_timeout(wdt_timeout),
        .pin_wake   (pin_wake),
        .osc_mode   (osc_mode),
        .core_hold  (core_hold)
    );

    function automatic int expect_len(input int code, input bit por);
        if (code <= 2) return LONG_N;
        return por ? FPOR_N : FLATE_N;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    // ticks until core_hold falls; 0 when it never falls
    task automatic measure(input int limit, output int got);
        got = 0;
        for (int k = 1; k <= limit; k++) begin
            one_tick();
            if (core_hold == 1'b0) begin
                got = k;
                break;
            end
        end
    endtask

    // kind: 0 power-on, 1 master-clear, 2 watchdog, 3 pin wake
    task automatic fire(input int kind);
        @(negedge clk);
        case (kind)
            0: por_req = 1'b1;
            1: mclr_n = 1'b0;
            2: wdt_timeout = 1'b1;
            default: pin_wake = 1'b1;
        endcase
        @(negedge clk);
        por_req = 1'b0;
        mclr_n = 1'b1;
        wdt_timeout = 1'b0;
        pin_wake = 1'b0;
        if (kind < 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int got;
        repeat (3) @(negedge clk);
        check("R11 hold in reset", int'(core_hold), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 hold after reset", int'(core_hold), 1);
        // first interval after reset is a power-on one (code 0 -> long)
        measure(LONG_N + 4, got);
        check("R11 first interval power-on length", got, LONG_N);

        // R1: a held level request keeps the core in reset despite ticks
        @(negedge clk) mclr_n = 1'b0;
        for (int k = 0; k < 6; k++) one_tick();
        check("R1 held by master-clear level", int'(core_hold), 1);
        mclr_n = 1'b1;
        @(negedge clk);

        // sweep: every mode code against every cause (R2 R3 R4 R5 R6)
        for (int code = 0; code < 8; code++) begin
            for (int kind = 0; kind < 4; kind++) begin
                string tag;
                osc_mode = 3'(code);
                fire(kind);
                check("R6 R1 held at interval start", int'(core_hold), 1);
                measure(LONG_N + 4, got);
                tag = (kind == 0) ? "R2" : "R3";
                tag = {tag, (code <= 2) ? " R4" : " R5"};
                check(tag, got, expect_len(code, kind == 0));
            end
        end

        // R7: master-clear during a power-on interval -> later length
        osc_mode = 3'd3;
        fire(0);
        one_tick();
        one_tick();
        fire(1);
        measure(LONG_N + 4, got);
        check("R7 restart takes new type", got, FLATE_N);

        // R7: mode code sampled at the restart
        fire(2);
        osc_mode = 3'd1;
        fire(3);
        measure(LONG_N + 4, got);
        check("R7 restart samples mode", got, LONG_N);

        // R9: restart pulse collides with the final tick
        osc_mode = 3'd2;
        fire(2);
        for (int k = 0; k < LONG_N - 1; k++) one_tick();
        check("R8 not released one tick early", int'(core_hold), 1);
        @(negedge clk) begin tick = 1'b1; pin_wake = 1'b1; end
        @(negedge clk) begin tick = 1'b0; pin_wake = 1'b0; end
        check("R9 collision keeps hold", int'(core_hold), 1);
        measure(LONG_N + 4, got);
        check("R9 full interval after collision", got, LONG_N);

        // R9: tick in the restart cycle of a short interval is not counted
        osc_mode = 3'd6;
        fire(2);
        @(negedge clk) begin tick = 1'b1; wdt_timeout = 1'b1; end
        @(negedge clk) begin tick = 1'b0; wdt_timeout = 1'b0; end
        check("R9 restart-cycle tick ignored", int'(core_hold), 1);
        measure(8, got);
        check("R9 one tick still needed", got, FLATE_N);

        // R10: pulse while power-on level is held leaves power-on type
        osc_mode = 3'd4;
        @(negedge clk) por_req = 1'b1;
        @(negedge clk) wdt_timeout = 1'b1;
        @(negedge clk) wdt_timeout = 1'b0;
        @(negedge clk) por_req = 1'b0;
        @(negedge clk);
        check("R10 held during power-on", int'(core_hold), 1);
        measure(LONG_N + 4, got);
        check("R10 power-on length kept", got, FPOR_N);

        // R1: ticks before release are not counted
        osc_mode = 3'd5;
        @(negedge clk) por_req = 1'b1;
        for (int k = 0; k < 4; k++) one_tick();
        @(negedge clk) por_req = 1'b0;
        @(negedge clk);
        measure(LONG_N + 4, got);
        check("R1 no counting while held", got, FPOR_N);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule